// File: doc/BRIEF.md
# Sub-DAC Setting Scan Chain with Stage Forcing

This block holds the reference-select settings that drive the sub-DACs of a multi-step converter. There is one setting per decision stage: the coarse stage and the mid stage. Each setting is a 4-bit decision plus a single test-control bit. The test-control bit asks the analog side for extra reference current so that the DAC output span matches the converter input span. In functional operation each stage's setting follows its decision logic on every clock.

A single serial chain runs through all the settings. A freeze input stops the live settings from tracking, so a capture pulse can load a coherent snapshot into the chain. That snapshot can then be shifted out one bit per clock.

For stage testing, a pattern is shifted in and committed to a shadow register with an update pulse. A mode input then chooses which stage is under test. For a mid-stage test the coarse setting comes from the shadow. For a fine-stage test both the coarse and the mid settings come from the shadow. Because the shadow changes only on update, shifting never disturbs what the DACs see.

Top module: `subdac_scan_chain`

## Requirements
- R1: While rst_n is low, every setting, the chain, the shadow, dac_sel, dac_tcb and scan_out are zero.
- R2: With freeze low, the live setting of each stage takes dec_in on each rising clock edge. In mode 0 it appears on dac_sel one cycle after dec_in is presented. Stage 0 (coarse) uses bits 3:0 and stage 1 (mid) uses bits 7:4.
- R3: While freeze is high the live settings hold their value whatever dec_in does. Tracking resumes on the first edge after freeze falls.
- R4: A capture pulse loads the chain in one edge. Bits 3:0 take the live coarse value, bit 4 the shadow coarse test bit, bits 8:5 the live mid value and bit 9 the shadow mid test bit. Capture takes priority over shift in the same cycle.
- R5: With shift_en high and capture low, the chain moves one place per edge towards bit 0. scan_in enters bit 9 and scan_out always shows bit 0, so the coarse LSB leaves first.
- R6: An update pulse with shift_en low copies the whole chain into the shadow. An update pulse with shift_en high is ignored.
- R7: Without an accepted update, the shadow, and so every forced dac_sel field and dac_tcb, stays unchanged during shifting.
- R8: Mode 1 (mid test) drives dac_sel[3:0] from shadow bits 3:0 and dac_sel[7:4] from the live mid setting.
- R9: Mode 2 (fine test) drives dac_sel[3:0] from shadow bits 3:0 and dac_sel[7:4] from shadow bits 8:5.
- R10: Mode 3 is reserved and behaves like mode 0: both fields come from the live settings.
- R11: dac_tcb[0] equals shadow bit 4 and dac_tcb[1] equals shadow bit 9 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 2 | 0 normal, 1 mid-stage test, 2 fine-stage test, 3 reserved (normal) |
| dec_in | input | 8 | Functional decisions, coarse in 3:0, mid in 7:4 |
| freeze | input | 1 | Stops the live settings from tracking dec_in |
| capture | input | 1 | Loads the live snapshot into the chain |
| shift_en | input | 1 | Shifts the chain by one bit |
| scan_in | input | 1 | Serial data into chain bit 9 |
| update | input | 1 | Commits the chain into the shadow |
| scan_out | output | 1 | Chain bit 0 |
| dac_sel | output | 8 | Settings to the sub-DACs, coarse in 3:0, mid in 7:4 |
| dac_tcb | output | 2 | Reference-current boost request per sub-DAC |

## Verification
A live setting that fails to hold under freeze shows up on dac_sel in normal mode on the very next cycle. It also reappears later inside a captured snapshot on scan_out. A misordered chain, or a shift that moves the wrong way, shows on scan_out within ten shift cycles of a capture or shift-in. A shadow that reacts to shifting, or to an update while shifting, shows at once on dac_tcb and on the forced dac_sel fields in the test modes. The stimulus therefore mixes random modes, freezes, captures and updates, and compares every output against a bench model on every cycle.

// File: rtl/subdac_scan_pkg.sv
package subdac_scan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_MID    = 2'd1,
    MODE_FINE   = 2'd2,
    MODE_RSVD   = 2'd3
  } test_mode_e;

  // A stage is forced from the shadow when the stage under test lies after it.
  function automatic logic stage_forced(input int mode_v, input int stage, input int nstage);
    return (mode_v > stage) && (mode_v <= nstage);
  endfunction

  // Lowest chain bit of a stage field (decision bits followed by test bit).
  function automatic int field_lsb(input int stage, input int dec_w);
    return stage * (dec_w + 1);
  endfunction

endpackage

// File: rtl/subdac_live_reg.sv
module subdac_live_reg #(
  parameter int DEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [DEC_W-1:0] dec_d,
  output logic [DEC_W-1:0] live_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    live_q <= '0;
    else if (!hold) live_q <= dec_d;
  end
endmodule

// File: rtl/subdac_scan_shift.sv
module subdac_scan_shift #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift_en,
  input  logic         scan_in,
  input  logic [W-1:0] cap_data,
  output logic [W-1:0] chain_q,
  output logic         scan_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (capture)  chain_q <= cap_data;
    else if (shift_en) chain_q <= {scan_in, chain_q[W-1:1]};
  end

  assign scan_out = chain_q[0];
endmodule

// File: rtl/subdac_shadow.sv
module subdac_shadow #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] chain_d,
  output logic [W-1:0] shadow_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= chain_d;
  end
endmodule

// File: rtl/subdac_scan_chain.sv
module subdac_scan_chain
  import subdac_scan_pkg::*;
#(
  parameter int DEC_W  = 4,
  parameter int NSTAGE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              test_mode,
  input  logic [NSTAGE*DEC_W-1:0] dec_in,
  input  logic                    freeze,
  input  logic                    capture,
  input  logic                    shift_en,
  input  logic                    scan_in,
  input  logic                    update,
  output logic                    scan_out,
  output logic [NSTAGE*DEC_W-1:0] dac_sel,
  output logic [NSTAGE-1:0]       dac_tcb
);
  localparam int FLD_W   = DEC_W + 1;
  localparam int CHAIN_W = NSTAGE * FLD_W;
  localparam int SEL_W   = NSTAGE * DEC_W;

  logic [SEL_W-1:0]   live_bus;
  logic [CHAIN_W-1:0] cap_data;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] shadow_q;
  logic               update_go;

  assign update_go = update & ~shift_en;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int LSB = field_lsb(s, DEC_W);
    logic forced;

    subdac_live_reg #(.DEC_W(DEC_W)) i_live (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (freeze),
      .dec_d  (dec_in[s*DEC_W +: DEC_W]),
      .live_q (live_bus[s*DEC_W +: DEC_W])
    );

    assign cap_data[LSB +: DEC_W]   = live_bus[s*DEC_W +: DEC_W];
    assign cap_data[LSB + DEC_W]    = shadow_q[LSB + DEC_W];
    assign forced                   = stage_forced(int'(test_mode), s, NSTAGE);
    assign dac_sel[s*DEC_W +: DEC_W] = forced ? shadow_q[LSB +: DEC_W]
                                              : live_bus[s*DEC_W +: DEC_W];
    assign dac_tcb[s]               = shadow_q[LSB + DEC_W];
  end

  subdac_scan_shift #(.W(CHAIN_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .shift_en (shift_en),
    .scan_in  (scan_in),
    .cap_data (cap_data),
    .chain_q  (chain_q),
    .scan_out (scan_out)
  );

  subdac_shadow #(.W(CHAIN_W)) i_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (update_go),
    .chain_d  (chain_q),
    .shadow_q (shadow_q)
  );
endmodule

// File: rtl/subdac_scan_chain_chk.sv
module subdac_scan_chain_chk #(
  parameter int DEC_W  = 4,
  parameter int NSTAGE = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    test_mode,
  input logic [NSTAGE*DEC_W-1:0]       dec_in,
  input logic                          freeze,
  input logic                          capture,
  input logic                          shift_en,
  input logic                          scan_in,
  input logic                          scan_out,
  input logic [NSTAGE*DEC_W-1:0]       dac_sel,
  input logic [NSTAGE-1:0]             dac_tcb,
  input logic [NSTAGE*DEC_W-1:0]       live_bus,
  input logic [NSTAGE*(DEC_W+1)-1:0]   chain_q,
  input logic [NSTAGE*(DEC_W+1)-1:0]   shadow_q,
  input logic                          update_go
);
  localparam int CHAIN_W = NSTAGE * (DEC_W + 1);

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> (dac_tcb == '0 && scan_out == 1'b0));

  // R2
  live_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> live_bus == $past(dec_in));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(live_bus));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture) |=> chain_q == {$past(scan_in), $past(chain_q[CHAIN_W-1:1])});

  // R6
  update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_go |=> shadow_q == $past(chain_q));

  // R7
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_go |=> $stable(shadow_q));

  // R10
  normal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'd0 || test_mode == 2'd3) |-> dac_sel == live_bus);

  // R9
  fine_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode == 2'd2 |-> (dac_sel[DEC_W-1:0] == shadow_q[DEC_W-1:0]));

  // R11
  tcb_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_tcb[0] == shadow_q[DEC_W]);
endmodule

bind subdac_scan_chain subdac_scan_chain_chk #(.DEC_W(DEC_W), .NSTAGE(NSTAGE)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_mode (test_mode),
  .dec_in    (dec_in),
  .freeze    (freeze),
  .capture   (capture),
  .shift_en  (shift_en),
  .scan_in   (scan_in),
  .scan_out  (scan_out),
  .dac_sel   (dac_sel),
  .dac_tcb   (dac_tcb),
  .live_bus  (live_bus),
  .chain_q   (chain_q),
  .shadow_q  (shadow_q),
  .update_go (update_go)
);

// File: tb/test_subdac_scan_chain.sv
module test_subdac_scan_chain;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] test_mode = 2'd0;
  logic [7:0] dec_in = '0;
  logic       freeze = 1'b0, capture = 1'b0, shift_en = 1'b0, scan_in = 1'b0, update = 1'b0;
  logic       scan_out;
  logic [7:0] dac_sel;
  logic [1:0] dac_tcb;

  int checks = 0;
  int fails  = 0;

  // bench model of the requirement-level state
  logic [7:0] m_live  = '0;
  logic [9:0] m_chain = '0;
  logic [9:0] m_shad  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subdac_scan_chain i_subdac_scan_chain (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .dec_in(dec_in),
    .freeze(freeze), .capture(capture), .shift_en(shift_en), .scan_in(scan_in),
    .update(update), .scan_out(scan_out), .dac_sel(dac_sel), .dac_tcb(dac_tcb)
  );

  // R4 field positions: coarse 3:0, coarse tcb 4, mid 8:5, mid tcb 9
  function automatic logic [9:0] snap(input logic [7:0] live, input logic [9:0] shad);
    return {shad[9], live[7:4], shad[4], live[3:0]};
  endfunction

  function automatic logic [7:0] exp_sel(input logic [1:0] md, input logic [7:0] live,
                                         input logic [9:0] shad);
    logic [3:0] c, m;
    c = (md == 2'd1 || md == 2'd2) ? shad[3:0] : live[3:0];
    m = (md == 2'd2) ? shad[8:5] : live[7:4];
    return {m, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live <= '0; m_chain <= '0; m_shad <= '0;
    end else begin
      if (!freeze) m_live <= dec_in;
      if (capture) m_chain <= snap(m_live, m_shad);
      else if (shift_en) m_chain <= {scan_in, m_chain[9:1]};
      if (update && !shift_en) m_shad <= m_chain;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'd1: return "R8";
      2'd2: return "R9";
      2'd3: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check_all(input string tag);
    string t;
    t = (tag == "") ? mode_tag(test_mode) : tag;
    chk((tag == "") ? "R5" : tag, 32'(scan_out), 32'(m_chain[0]));
    chk(t, 32'(dac_sel), 32'(exp_sel(test_mode, m_live, m_shad)));
    chk((tag == "") ? "R11" : tag, 32'(dac_tcb), 32'({m_shad[9], m_shad[4]}));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic shift_word(input logic [9:0] w, input logic upd, input string tag);
    for (int i = 0; i < 10; i++) begin
      shift_en = 1'b1; scan_in = w[i]; update = upd;
      step(tag);
    end
    shift_en = 1'b0; update = 1'b0; scan_in = 1'b0;
  endtask

  initial begin
    logic [7:0] held;
    logic [9:0] got;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 32'({dac_sel, dac_tcb, scan_out}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 normal tracking
    dec_in = 8'h5A; step("R2");
    chk("R2", 32'(dac_sel), 32'h5A);

    // R3 freeze holds
    freeze = 1'b1; held = 8'h5A;
    dec_in = 8'hC3; step("R3");
    dec_in = 8'h17; step("R3");
    chk("R3", 32'(dac_sel), 32'(held));
    freeze = 1'b0; step("R3");
    chk("R3", 32'(dac_sel), 32'h17);

    // R4 capture with simultaneous shift, then shift out
    freeze = 1'b1; capture = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
    step("R4");
    capture = 1'b0; shift_en = 1'b0;
    got = '0;
    for (int i = 0; i < 10; i++) begin
      got[i] = scan_out;
      shift_en = 1'b1; scan_in = 1'b0;
      step("R4");
    end
    shift_en = 1'b0;
    chk("R4", 32'(got), 32'({1'b0, 4'h1, 1'b0, 4'h7}));

    // R6 update during shift ignored, then committed
    shift_word(10'b1_1001_1_0110, 1'b1, "R6");
    chk("R6", 32'(dac_tcb), 32'd0);
    update = 1'b1; step("R6"); update = 1'b0;
    chk("R6", 32'(dac_tcb), 32'b11);

    // R9 forcing both stages, R7 shifting leaves outputs alone
    test_mode = 2'd2; step("R9");
    chk("R9", 32'(dac_sel), 32'h96);
    shift_word(10'h155, 1'b0, "R7");
    chk("R7", 32'({dac_sel, dac_tcb}), 32'({8'h96, 2'b11}));

    // R8 mid test, R10 reserved mode
    freeze = 1'b0; dec_in = 8'hE2;
    test_mode = 2'd1; step("R8");
    chk("R8", 32'(dac_sel), 32'hE6);
    test_mode = 2'd3; step("R10");
    chk("R10", 32'(dac_sel), 32'hE2);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      test_mode = 2'($urandom_range(0, 3));
      dec_in    = 8'($urandom);
      freeze    = ($urandom_range(0, 3) == 0);
      capture   = ($urandom_range(0, 15) == 0);
      shift_en  = ($urandom_range(0, 1) == 0);
      scan_in   = 1'($urandom);
      update    = ($urandom_range(0, 7) == 0);
      step("");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule